// File: doc/BRIEF.md
# Narrow Operand-Capturing Issue Window

This block is an out-of-order issue window that keeps the low 16-bit slice of every source operand inside its entries. Each entry has its own small ALU. While the age-ordered selector picks the oldest instruction whose operands are all present, every entry's ALU has already worked out its narrow result. The selected entry's result, carry and destination tag are driven onto the issue port in the same cycle. That port also acts as the internal wakeup bus. Waiting sources compare their tags against this bus and against a set of external result lanes. On a match they capture the 16-bit value, so a dependent simple operation issues in the very next cycle without any speculation.

Each entry is a three-state machine. `SLOT_FREE` goes to `SLOT_WAIT` on dispatch when an operand is missing, or straight to `SLOT_READY` when both operands are present or captured that cycle. `SLOT_WAIT` goes to `SLOT_READY` once the last missing operand is captured. `SLOT_READY` goes back to `SLOT_FREE` in the cycle it is granted, so the entry is reusable from the next cycle. Dispatch fills the lowest-numbered free entry. An age matrix records dispatch order independently of entry position.

Top module: `nsched_window`

## Requirements
- R1: After reset every entry is free: `disp_ready` is 1 and `iss_valid` is 0.
- R2: A dispatch is taken only when `disp_valid` and `disp_ready` are both 1. With all ENTRIES slots occupied, `disp_ready` is 0 and a dispatch presented then leaves no trace: no extra instruction ever issues.
- R3: An instruction dispatched with both operands ready issues in the cycle after its dispatch cycle. Its `iss_result` is the 16-bit result of its operation, with `disp_op` codes 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR.
- R4: `iss_carry` is bit 16 of a+b for add, is 1 exactly when a is at least b (unsigned) for subtract, and is 0 for the logic operations.
- R5: At most one instruction issues per cycle. Among ready entries, the one dispatched earliest issues first, whatever slot it sits in.
- R6: An instruction whose source tag equals the `iss_dst` of an issuing instruction captures that `iss_result` and can issue in the next cycle.
- R7: An external lane with `ext_valid` set wakes each waiting source whose tag matches its tag and delivers its data. The woken instruction can issue in the cycle after the broadcast.
- R8: A source dispatched not ready captures a matching broadcast (internal or external) presented in the same cycle as its dispatch.
- R9: A granted entry is freed at the end of its issue cycle, and each dispatched instruction issues exactly once.
- R10: An instruction with a source still missing never issues, and broadcasts of other tags do not wake it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | At least one free entry |
| disp_op | input | 3 | Narrow operation code |
| disp_dst | input | TAG_W | Destination tag |
| disp_tag_a | input | TAG_W | Source A tag |
| disp_rdy_a | input | 1 | Source A value supplied |
| disp_val_a | input | SLICE_W | Source A low slice |
| disp_tag_b | input | TAG_W | Source B tag |
| disp_rdy_b | input | 1 | Source B value supplied |
| disp_val_b | input | SLICE_W | Source B low slice |
| ext_valid | input | NUM_EXT | External result lane valid |
| ext_tag | input | NUM_EXT*TAG_W | External lane tags, lane 0 lowest |
| ext_data | input | NUM_EXT*SLICE_W | External lane low slices |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_op | output | 3 | Issued operation code |
| iss_dst | output | TAG_W | Issued destination tag, also the wakeup tag |
| iss_result | output | SLICE_W | Narrow result, also the wakeup data |
| iss_carry | output | 1 | Carry out of the top slice bit |

## Verification
Independent ready instructions with edge values (carry-producing add, borrow and no-borrow subtract, logic mixes) separate the operation decoding and the carry rule. A pair woken by one broadcast, where the younger sits in a lower slot, shows whether selection follows age or position. A three-deep chain started by an external broadcast exposes any extra cycle in the internal wakeup loop. A dispatch that coincides with its producer's broadcast checks the capture race. Finally, the window is filled completely and an extra dispatch is offered; a stray issue or a missing one reveals a broken full check or a lost slot.

// File: rtl/nsched_pkg.sv
package nsched_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } nop_e;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_e;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/nsched_alu.sv
module nsched_alu
    import nsched_pkg::*;
#(
    parameter int SLICE_W = 16
) (
    input  logic [2:0]         op,
    input  logic [SLICE_W-1:0] opa,
    input  logic [SLICE_W-1:0] opb,
    output logic [SLICE_W-1:0] res,
    output logic               cout
);
    logic [SLICE_W:0] sum_w;
    logic [SLICE_W:0] dif_w;

    always_comb begin
        sum_w = {1'b0, opa} + {1'b0, opb};
        dif_w = {1'b0, opa} + {1'b0, ~opb} + {{SLICE_W{1'b0}}, 1'b1};
        res   = '0;
        cout  = 1'b0;
        case (op)
            OP_ADD: begin res = sum_w[SLICE_W-1:0]; cout = sum_w[SLICE_W]; end
            OP_SUB: begin res = dif_w[SLICE_W-1:0]; cout = dif_w[SLICE_W]; end
            OP_AND: res = opa & opb;
            OP_OR:  res = opa | opb;
            OP_XOR: res = opa ^ opb;
            default: begin res = '0; cout = 1'b0; end
        endcase
    end
endmodule

// File: rtl/nsched_entry.sv
module nsched_entry
    import nsched_pkg::*;
#(
    parameter int SLICE_W = 16,
    parameter int TAG_W   = 6,
    parameter int NB      = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc,
    input  logic [2:0]                        a_op,
    input  logic [TAG_W-1:0]                  a_dst,
    input  logic [NUM_SRC-1:0][TAG_W-1:0]     a_tag,
    input  logic [NUM_SRC-1:0]                a_rdy,
    input  logic [NUM_SRC-1:0][SLICE_W-1:0]   a_val,
    input  logic [NB-1:0]                     bc_valid,
    input  logic [NB-1:0][TAG_W-1:0]          bc_tag,
    input  logic [NB-1:0][SLICE_W-1:0]        bc_data,
    input  logic                              grant,
    output logic                              is_free,
    output logic                              req,
    output logic [2:0]                        out_op,
    output logic [TAG_W-1:0]                  out_dst,
    output logic [SLICE_W-1:0]                out_res,
    output logic                              out_cout
);
    slot_e state_q, state_d;

    logic [2:0]                      op_q;
    logic [TAG_W-1:0]                dst_q;
    logic [NUM_SRC-1:0][TAG_W-1:0]   tag_q;
    logic [NUM_SRC-1:0]              rdy_q;
    logic [NUM_SRC-1:0][SLICE_W-1:0] val_q;

    logic [NUM_SRC-1:0][TAG_W-1:0]   cmp_tag;
    logic [NUM_SRC-1:0]              hit;
    logic [NUM_SRC-1:0][SLICE_W-1:0] hit_data;
    logic [NUM_SRC-1:0]              rdy_n;

    // tag comparators: lowest lane wins when several match
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            cmp_tag[s]  = alloc ? a_tag[s] : tag_q[s];
            hit[s]      = 1'b0;
            hit_data[s] = '0;
            for (int b = NB - 1; b >= 0; b--) begin
                if (bc_valid[b] && (bc_tag[b] == cmp_tag[s])) begin
                    hit[s]      = 1'b1;
                    hit_data[s] = bc_data[b];
                end
            end
            if (alloc) rdy_n[s] = a_rdy[s] | hit[s];
            else       rdy_n[s] = rdy_q[s] | hit[s];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc) state_d = (&rdy_n) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (&rdy_n) state_d = SLOT_READY;
            SLOT_READY: if (grant) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            dst_q <= '0;
            tag_q <= '0;
            rdy_q <= '0;
            val_q <= '0;
        end else if (alloc) begin
            op_q  <= a_op;
            dst_q <= a_dst;
            for (int s = 0; s < NUM_SRC; s++) begin
                tag_q[s] <= a_tag[s];
                rdy_q[s] <= rdy_n[s];
                val_q[s] <= a_rdy[s] ? a_val[s] : hit_data[s];
            end
        end else if (state_q == SLOT_WAIT) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (!rdy_q[s] && hit[s]) begin
                    rdy_q[s] <= 1'b1;
                    val_q[s] <= hit_data[s];
                end
            end
        end
    end

    // replicated narrow ALU, evaluated alongside selection
    nsched_alu #(.SLICE_W(SLICE_W)) u_alu (
        .op   (op_q),
        .opa  (val_q[0]),
        .opb  (val_q[1]),
        .res  (out_res),
        .cout (out_cout)
    );

    // outputs
    always_comb begin
        is_free = (state_q == SLOT_FREE);
        req     = (state_q == SLOT_READY);
        out_op  = op_q;
        out_dst = dst_q;
    end

    // R2: dispatch only lands in a free slot
    a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> state_q == SLOT_FREE);
    // R9: a granted slot is free in the following cycle
    a_r9_grant_frees: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> state_q == SLOT_FREE);
    // R10: a grant never reaches a slot with a missing operand
    a_r10_grant_operands: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> &rdy_q);
endmodule

// File: rtl/nsched_age_sel.sv
module nsched_age_sel #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_vec,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // older_q[j][i] = 1 means slot j was dispatched before slot i
    logic [N-1:0][N-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc_vec[k]) begin
                    for (int j = 0; j < N; j++) begin
                        older_q[k][j] <= 1'b0;
                        if (j != k) older_q[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (req[j] && older_q[j][i]) blocked = 1'b1;
            end
            grant[i] = req[i] & ~blocked;
        end
    end

    // R5: one issue per cycle
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R5: age order is never contradictory for any pair
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < i; j++) begin
                    a_r5_age_antisym: assert (!(older_q[i][j] && older_q[j][i]));
                end
            end
        end
    end
endmodule

// File: rtl/nsched_window.sv
module nsched_window
    import nsched_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int SLICE_W = 16,
    parameter int TAG_W   = 6,
    parameter int NUM_EXT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       disp_valid,
    output logic                       disp_ready,
    input  logic [2:0]                 disp_op,
    input  logic [TAG_W-1:0]           disp_dst,
    input  logic [TAG_W-1:0]           disp_tag_a,
    input  logic                       disp_rdy_a,
    input  logic [SLICE_W-1:0]         disp_val_a,
    input  logic [TAG_W-1:0]           disp_tag_b,
    input  logic                       disp_rdy_b,
    input  logic [SLICE_W-1:0]         disp_val_b,
    input  logic [NUM_EXT-1:0]         ext_valid,
    input  logic [NUM_EXT*TAG_W-1:0]   ext_tag,
    input  logic [NUM_EXT*SLICE_W-1:0] ext_data,
    output logic                       iss_valid,
    output logic [2:0]                 iss_op,
    output logic [TAG_W-1:0]           iss_dst,
    output logic [SLICE_W-1:0]         iss_result,
    output logic                       iss_carry
);
    localparam int NB = NUM_EXT + 1;

    logic [ENTRIES-1:0]              free_vec;
    logic [ENTRIES-1:0]              req_vec;
    logic [ENTRIES-1:0]              grant_vec;
    logic [ENTRIES-1:0]              alloc_vec;
    logic [ENTRIES-1:0][2:0]         e_op;
    logic [ENTRIES-1:0][TAG_W-1:0]   e_dst;
    logic [ENTRIES-1:0][SLICE_W-1:0] e_res;
    logic [ENTRIES-1:0]              e_cout;

    logic [NB-1:0]                   bc_valid;
    logic [NB-1:0][TAG_W-1:0]        bc_tag;
    logic [NB-1:0][SLICE_W-1:0]      bc_data;
    logic [NUM_SRC-1:0][TAG_W-1:0]   d_tag;
    logic [NUM_SRC-1:0]              d_rdy;
    logic [NUM_SRC-1:0][SLICE_W-1:0] d_val;
    logic                            disp_fire;

    // lane 0 is the internal issue broadcast, external lanes follow
    assign bc_valid = {ext_valid, iss_valid};
    assign bc_tag   = {ext_tag, iss_dst};
    assign bc_data  = {ext_data, iss_result};
    assign d_tag    = {disp_tag_b, disp_tag_a};
    assign d_rdy    = {disp_rdy_b, disp_rdy_a};
    assign d_val    = {disp_val_b, disp_val_a};

    assign disp_ready = |free_vec;
    assign disp_fire  = disp_valid & disp_ready;

    // lowest free slot receives the dispatch
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_vec = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (!found && free_vec[k]) begin
                alloc_vec[k] = disp_fire;
                found        = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        nsched_entry #(
            .SLICE_W (SLICE_W),
            .TAG_W   (TAG_W),
            .NB      (NB)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_vec[g]),
            .a_op     (disp_op),
            .a_dst    (disp_dst),
            .a_tag    (d_tag),
            .a_rdy    (d_rdy),
            .a_val    (d_val),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .grant    (grant_vec[g]),
            .is_free  (free_vec[g]),
            .req      (req_vec[g]),
            .out_op   (e_op[g]),
            .out_dst  (e_dst[g]),
            .out_res  (e_res[g]),
            .out_cout (e_cout[g])
        );
    end

    nsched_age_sel #(.N(ENTRIES)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vec (alloc_vec),
        .req       (req_vec),
        .grant     (grant_vec)
    );

    // issue mux over the one-hot grant
    always_comb begin
        iss_valid  = |grant_vec;
        iss_op     = '0;
        iss_dst    = '0;
        iss_result = '0;
        iss_carry  = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (grant_vec[k]) begin
                iss_op     = iss_op | e_op[k];
                iss_dst    = iss_dst | e_dst[k];
                iss_result = iss_result | e_res[k];
                iss_carry  = iss_carry | e_cout[k];
            end
        end
    end

    // R3: an issue happens only when some slot was occupied
    a_r3_issue_needs_occupant: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !(&free_vec));
    // R2: a blocked dispatch allocates nothing
    a_r2_full_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ready |-> alloc_vec == '0);
endmodule

// File: tb/nsched_window_bench.sv
module nsched_window_bench;
    localparam int N  = 32;
    localparam int W  = 16;
    localparam int TW = 6;
    localparam int NE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic disp_ready;
    logic [2:0] disp_op = '0;
    logic [TW-1:0] disp_dst = '0, disp_tag_a = '0, disp_tag_b = '0;
    logic disp_rdy_a = 1'b0, disp_rdy_b = 1'b0;
    logic [W-1:0] disp_val_a = '0, disp_val_b = '0;
    logic [NE-1:0] ext_valid = '0;
    logic [NE*TW-1:0] ext_tag = '0;
    logic [NE*W-1:0] ext_data = '0;
    logic iss_valid, iss_carry;
    logic [2:0] iss_op;
    logic [TW-1:0] iss_dst;
    logic [W-1:0] iss_result;

    always #4 clk = ~clk;  // 125 MHz

    nsched_window #(.ENTRIES(N), .SLICE_W(W), .TAG_W(TW), .NUM_EXT(NE)) u_nsched_window (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_tag_a(disp_tag_a), .disp_rdy_a(disp_rdy_a), .disp_val_a(disp_val_a),
        .disp_tag_b(disp_tag_b), .disp_rdy_b(disp_rdy_b), .disp_val_b(disp_val_b),
        .ext_valid(ext_valid), .ext_tag(ext_tag), .ext_data(ext_data),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_result(iss_result), .iss_carry(iss_carry)
    );

    typedef struct {
        logic [TW-1:0] tag;
        logic [W-1:0]  res;
        logic          cout;
        int            cyc;
        int            rq;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W:0] ref_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        int unsigned s;
        case (op)
            3'd0: begin s = int'(a) + int'(b); return {s[16], s[15:0]}; end
            3'd1: return {a >= b, W'(a - b)};
            3'd2: return {1'b0, a & b};
            3'd3: return {1'b0, a | b};
            default: return {1'b0, a ^ b};
        endcase
    endfunction

    task automatic chk(input bit ok, input int rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every issue
    always @(negedge clk) begin
        if (rst_n && !done && iss_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, 9, "unexpected issue tag", int'(iss_dst), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(iss_dst == e.tag, e.rq, "issue tag", int'(iss_dst), int'(e.tag));
                chk(iss_result == e.res, e.rq, "issue result", int'(iss_result), int'(e.res));
                chk(iss_carry == e.cout, 4, "issue carry", int'(iss_carry), int'(e.cout));
                if (e.cyc >= 0) chk(cyc == e.cyc, e.rq, "issue cycle", cyc, e.cyc);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        disp_valid = 1'b0;
        ext_valid  = '0;
    endtask

    task automatic set_disp(input logic [2:0] op, input int dst,
                            input int ta, input bit ra, input int va,
                            input int tb, input bit rb, input int vb);
        disp_valid = 1'b1; disp_op = op; disp_dst = TW'(dst);
        disp_tag_a = TW'(ta); disp_rdy_a = ra; disp_val_a = W'(va);
        disp_tag_b = TW'(tb); disp_rdy_b = rb; disp_val_b = W'(vb);
    endtask

    task automatic set_ext(input int lane, input int tag, input int data);
        ext_valid[lane] = 1'b1;
        ext_tag[lane*TW +: TW] = TW'(tag);
        ext_data[lane*W +: W] = W'(data);
    endtask

    task automatic push(input int dst, input logic [2:0] op, input int a, input int b, input int at, input int rq);
        exp_t e;
        logic [W:0] r;
        r = ref_op(op, W'(a), W'(b));
        e.tag = TW'(dst); e.res = r[W-1:0]; e.cout = r[W]; e.cyc = at; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic drain_check(input int rq);
        repeat (4) tick();
        chk(exp_q.size() == 0, rq, "pending issues", exp_q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(disp_ready == 1'b1, 1, "disp_ready after reset", int'(disp_ready), 1);
        chk(iss_valid == 1'b0, 1, "iss_valid after reset", int'(iss_valid), 0);
        tick();

        // R3 R4: independent ready instructions, each issues next cycle
        set_disp(3'd0, 1, 0, 1, 'h1234, 0, 1, 'h0fff); push(1, 3'd0, 'h1234, 'h0fff, cyc + 1, 3); tick();
        set_disp(3'd0, 2, 0, 1, 'hffff, 0, 1, 'h0001); push(2, 3'd0, 'hffff, 'h0001, cyc + 1, 4); tick();
        set_disp(3'd1, 3, 0, 1, 5, 0, 1, 7);           push(3, 3'd1, 5, 7, cyc + 1, 4); tick();
        set_disp(3'd1, 4, 0, 1, 7, 0, 1, 5);           push(4, 3'd1, 7, 5, cyc + 1, 4); tick();
        set_disp(3'd2, 5, 0, 1, 'ha5a5, 0, 1, 'h0ff0); push(5, 3'd2, 'ha5a5, 'h0ff0, cyc + 1, 3); tick();
        set_disp(3'd3, 6, 0, 1, 'ha5a5, 0, 1, 'h0ff0); push(6, 3'd3, 'ha5a5, 'h0ff0, cyc + 1, 3); tick();
        set_disp(3'd4, 7, 0, 1, 'ha5a5, 0, 1, 'hffff); push(7, 3'd4, 'ha5a5, 'hffff, cyc + 1, 3); tick();
        drain_check(3);

        // R5 R7: younger instruction in a lower slot issues after the older one
        set_disp(3'd0, 20, 40, 0, 0, 0, 1, 1); tick();
        set_disp(3'd0, 21, 41, 0, 0, 0, 1, 1); tick();
        set_ext(0, 40, 100); push(20, 3'd0, 100, 1, cyc + 1, 7); tick();
        tick(); tick();
        set_disp(3'd0, 22, 41, 0, 0, 0, 1, 2); tick();
        set_ext(1, 41, 7);
        push(21, 3'd0, 7, 1, cyc + 1, 5);
        push(22, 3'd0, 7, 2, cyc + 2, 5);
        tick();
        drain_check(5);

        // R6 R7: chain woken by one external broadcast issues back to back
        set_disp(3'd0, 30, 42, 0, 0, 0, 1, 3); tick();
        set_disp(3'd1, 31, 30, 0, 0, 0, 1, 10); tick();
        set_disp(3'd0, 32, 31, 0, 0, 31, 0, 0); tick();
        set_ext(0, 42, 'h0100);
        push(30, 3'd0, 'h0100, 3, cyc + 1, 7);
        push(31, 3'd1, 'h0103, 10, cyc + 2, 6);
        push(32, 3'd0, 'h00f9, 'h00f9, cyc + 3, 6);
        tick();
        drain_check(6);

        // R8: capture during the dispatch cycle, external and internal
        set_disp(3'd2, 33, 43, 0, 0, 0, 1, 'hffff); set_ext(1, 43, 50);
        push(33, 3'd2, 50, 'hffff, cyc + 1, 8); tick();
        set_disp(3'd0, 34, 0, 1, 5, 0, 1, 6); push(34, 3'd0, 5, 6, cyc + 1, 8); tick();
        set_disp(3'd4, 35, 34, 0, 0, 0, 1, 3); push(35, 3'd4, 11, 3, cyc + 1, 8); tick();
        drain_check(8);

        // R10: missing operand holds the instruction, other tags do not wake it
        set_disp(3'd0, 36, 44, 0, 0, 0, 1, 1); tick();
        set_ext(0, 45, 9); tick();
        set_ext(1, 47, 9); tick();
        repeat (5) tick();
        chk(exp_q.size() == 0, 10, "no early issue", exp_q.size(), 0);
        set_ext(1, 44, 9); push(36, 3'd0, 9, 1, cyc + 1, 10); tick();
        drain_check(10);

        // R2 R9: fill the window, offer one more, then release all
        for (int i = 0; i < N; i++) begin
            set_disp(3'd0, i, 46, 0, 0, 0, 1, i); tick();
        end
        @(negedge clk);
        chk(disp_ready == 1'b0, 2, "disp_ready when full", int'(disp_ready), 0);
        #1;
        set_disp(3'd0, 37, 0, 1, 1, 0, 1, 1); tick();
        repeat (3) tick();
        set_ext(0, 46, 'h0200);
        for (int i = 0; i < N; i++) push(i, 3'd0, 'h0200, i, cyc + 1 + i, 9);
        tick();
        repeat (N + 2) tick();
        chk(exp_q.size() == 0, 9, "all slots issued once", exp_q.size(), 0);
        @(negedge clk);
        chk(disp_ready == 1'b1, 9, "slots freed after issue", int'(disp_ready), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1'b1;
        checks++; fails++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule